// File: doc/BRIEF.md
# Register-Pair Exchange and Stack Unit

This block executes the register-pair transfer group of an 8-bit processor core. It holds the four main register pairs (BC, DE, HL and AF), the shadow copies of BC, DE and HL, the stack pointer and the two interrupt-enable flip-flops. It carries out pushes and pops of any main pair, the DE/HL swap, the main/shadow bank swap, the swap of HL with the word on top of the stack, loading SP from HL, and the interrupt enable and disable instructions.

An opcode is offered on `opCode` with `opValid` while `busy` is low. Register-only instructions finish on the next clock edge. Instructions that touch the stack run a sequence of single-byte accesses over a request/done memory port. Each completed instruction raises `opDone` for one cycle and presents its T-state cost on `tStates`. A load port presets any register while the unit is idle. Instruction fetch and arithmetic are handled elsewhere in the core.

Top module: `regx_stack_unit`

## Requirements
- R1: After reset all main pairs, shadow pairs and SP read 0, both interrupt flip-flops are clear, and `memReq`, `busy` and `opDone` are low.
- R2: A load with `wrEn` high takes effect on the next edge only if `busy` is low and `opValid` is low; otherwise it has no effect. The `wrSel` codes are 0 BC, 1 DE, 2 HL, 3 AF, 4 SP, 5 shadow BC, 6 shadow DE, 7 shadow HL.
- R3: Opcode 0xC5+16n pushes pair n (0 BC, 1 DE, 2 HL, 3 AF). The high byte is written to SP-1 and then the low byte to SP-2. SP ends at SP-2 and the cost is 11.
- R4: Opcode 0xC1+16n pops pair n. The low byte is read from SP and then the high byte from SP+1. SP ends at SP+2 and the cost is 10.
- R5: For the AF pair, A is the high byte and the flag byte is the low byte, both on the register outputs and in stack memory.
- R6: Opcode 0xD9 swaps BC, DE and HL with their shadow copies in a single edge and leaves AF unchanged. The cost is 4, and executing it twice restores every register.
- R7: Opcode 0xEB swaps DE and HL at a cost of 4.
- R8: Opcode 0xE3 reads the little-endian word at SP, writes HL there (L to SP, H to SP+1) and loads HL with the old word. SP never changes during or after it, and the cost is 19.
- R9: Opcode 0xF9 copies HL into SP at a cost of 6.
- R10: Opcode 0xF3 clears both interrupt flip-flops and 0xFB sets both. Each costs 4 and completes one cycle after acceptance.
- R11: Stack addresses and SP wrap modulo 65536.
- R12: Any other opcode completes one cycle after acceptance with a cost of 0. It changes no register and makes no memory access.
- R13: While `memReq` is high and `memDone` is low, the address, write enable and write data hold steady. Each `memDone` completes one byte. Push and pop make two accesses, 0xE3 makes four, and all other instructions make none. `memReq` is never high while `opDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Opcode offered; accepted when busy is low |
| opCode | input | 8 | Instruction opcode |
| busy | output | 1 | A stack sequence is in progress |
| opDone | output | 1 | One-cycle completion pulse |
| tStates | output | 5 | T-state cost of the completed instruction |
| memReq | output | 1 | Byte access request, held until memDone |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memDone |
| memDone | input | 1 | Access complete |
| wrEn | input | 1 | Register load strobe |
| wrSel | input | 3 | Register load select |
| wrData | input | 16 | Register load value |
| regBC | output | 16 | BC pair |
| regDE | output | 16 | DE pair |
| regHL | output | 16 | HL pair |
| regAF | output | 16 | AF pair (A high, flags low) |
| shBC | output | 16 | Shadow BC |
| shDE | output | 16 | Shadow DE |
| shHL | output | 16 | Shadow HL |
| regSP | output | 16 | Stack pointer |
| iff1 | output | 1 | Interrupt flip-flop 1 |
| iff2 | output | 1 | Interrupt flip-flop 2 |

## Verification
The assertions check on every cycle the properties of instructions that complete in one cycle: the bank and DE/HL swaps, the SP copy, the interrupt flip-flops and unknown opcodes. They also check that the memory request holds steady until it is answered, that SP is frozen during a stack sequence, and that a request never overlaps a completion. Only the bench scenarios can show the actual bytes placed on or taken from the stack. The bench also covers the byte order of AF, SP wrap at both ends of the address space, the restore after a double bank swap, and that a load during a running instruction is dropped. It answers memory requests with varying latency and compares every register against its own model on every clock.

// File: rtl/regx_stack_pkg.sv
package regx_stack_pkg;
  parameter int BYTE_W  = 8;
  parameter int WORD_W  = 2 * BYTE_W;
  parameter int ADDR_W  = 16;
  parameter int TS_W    = 5;
  parameter int STEP_W  = 2;
  parameter int SEL_W   = 3;
  parameter int PAIRS   = 4;
  parameter int SHADOWS = 3;
  localparam int IDX_DE = 1;
  localparam int IDX_HL = 2;

  typedef enum logic [3:0] {
    K_NONE, K_PUSH, K_POP, K_EXSP, K_EXDH, K_EXX, K_LDSP, K_DI, K_EI
  } kind_t;

  typedef enum logic [1:0] {A_SP0, A_SP1, A_SPM1, A_SPM2} addr_t;

  typedef struct packed {
    logic       exDeHl;
    logic       exx;
    logic       spFromHl;
    logic       intOff;
    logic       intOn;
    logic       capLo;
    logic       capHi;
    logic       pushDone;
    logic       popDone;
    logic       exSpDone;
    logic       hostOk;
    logic       wrHigh;
    logic [1:0] pairSel;
    addr_t      addrSel;
  } strobe_t;

  function automatic kind_t decodeOp(input logic [7:0] op);
    kind_t k;
    k = K_NONE;
    if (op[7:6] == 2'b11 && op[3:0] == 4'h5) k = K_PUSH;
    else if (op[7:6] == 2'b11 && op[3:0] == 4'h1) k = K_POP;
    else begin
      case (op)
        8'hE3: k = K_EXSP;
        8'hEB: k = K_EXDH;
        8'hD9: k = K_EXX;
        8'hF9: k = K_LDSP;
        8'hF3: k = K_DI;
        8'hFB: k = K_EI;
        default: k = K_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic usesMem(input kind_t k);
    return (k == K_PUSH) || (k == K_POP) || (k == K_EXSP);
  endfunction

  function automatic logic [TS_W-1:0] costOf(input kind_t k);
    logic [TS_W-1:0] c;
    case (k)
      K_PUSH:  c = TS_W'(11);
      K_POP:   c = TS_W'(10);
      K_EXSP:  c = TS_W'(19);
      K_LDSP:  c = TS_W'(6);
      K_EXDH, K_EXX, K_DI, K_EI: c = TS_W'(4);
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/regx_stack_ctrl.sv
module regx_stack_ctrl
  import regx_stack_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [7:0]      opCode,
  input  logic            memDone,
  output strobe_t         st,
  output logic            memReq,
  output logic            memWe,
  output logic            busy,
  output logic            opDone,
  output logic [TS_W-1:0] tStates
);
  logic              busyQ;
  kind_t             kindQ;
  logic [1:0]        selQ;
  logic [STEP_W-1:0] stepQ;
  logic              doneQ;
  logic [TS_W-1:0]   tsQ;
  logic              accept;
  logic              lastStep;
  kind_t             decK;

  assign decK   = decodeOp(opCode);
  assign accept = opValid && !busyQ;
  assign memReq = busyQ;
  assign busy   = busyQ;
  assign opDone = doneQ;
  assign tStates = tsQ;

  always_comb begin
    st         = '0;
    st.pairSel = selQ;
    st.hostOk  = !busyQ && !opValid;
    memWe      = 1'b0;
    lastStep   = 1'b0;
    if (accept) begin
      case (decK)
        K_EXDH: st.exDeHl   = 1'b1;
        K_EXX:  st.exx      = 1'b1;
        K_LDSP: st.spFromHl = 1'b1;
        K_DI:   st.intOff   = 1'b1;
        K_EI:   st.intOn    = 1'b1;
        default: ;
      endcase
    end
    if (busyQ) begin
      case (kindQ)
        K_PUSH: begin
          memWe       = 1'b1;
          st.addrSel  = (stepQ == 0) ? A_SPM1 : A_SPM2;
          st.wrHigh   = (stepQ == 0);
          lastStep    = (stepQ == 1);
          st.pushDone = memDone && lastStep;
        end
        K_POP: begin
          st.addrSel = stepQ[0] ? A_SP1 : A_SP0;
          lastStep   = (stepQ == 1);
          st.capLo   = memDone && (stepQ == 0);
          st.popDone = memDone && lastStep;
        end
        K_EXSP: begin
          memWe       = stepQ[1];
          st.addrSel  = stepQ[0] ? A_SP1 : A_SP0;
          st.wrHigh   = stepQ[0];
          lastStep    = (stepQ == 3);
          st.capLo    = memDone && (stepQ == 0);
          st.capHi    = memDone && (stepQ == 1);
          st.exSpDone = memDone && lastStep;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      kindQ <= K_NONE;
      selQ  <= '0;
      stepQ <= '0;
      doneQ <= 1'b0;
      tsQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        kindQ <= decK;
        selQ  <= (decK == K_EXSP) ? 2'(IDX_HL) : opCode[5:4];
        stepQ <= '0;
        if (usesMem(decK)) begin
          busyQ <= 1'b1;
        end else begin
          doneQ <= 1'b1;
          tsQ   <= costOf(decK);
        end
      end else if (busyQ && memDone) begin
        if (lastStep) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
          tsQ   <= costOf(kindQ);
        end else begin
          stepQ <= stepQ + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/regx_stack_dpath.sv
module regx_stack_dpath
  import regx_stack_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           st,
  input  logic [BYTE_W-1:0]                 memRdata,
  input  logic                              wrEn,
  input  logic [SEL_W-1:0]                  wrSel,
  input  logic [WORD_W-1:0]                 wrData,
  output logic [ADDR_W-1:0]                 memAddr,
  output logic [BYTE_W-1:0]                 memWdata,
  output logic [PAIRS-1:0][WORD_W-1:0]      pairsOut,
  output logic [SHADOWS-1:0][WORD_W-1:0]    shadowOut,
  output logic [ADDR_W-1:0]                 spOut,
  output logic                              iff1Out,
  output logic                              iff2Out
);
  logic [WORD_W-1:0] pairQ [PAIRS];
  logic [WORD_W-1:0] shQ   [SHADOWS];
  logic [ADDR_W-1:0] spQ;
  logic [WORD_W-1:0] tmpQ;
  logic              iff1Q, iff2Q;
  logic [WORD_W-1:0] pairRd;

  assign pairRd   = pairQ[st.pairSel];
  assign memWdata = st.wrHigh ? pairRd[WORD_W-1:BYTE_W] : pairRd[BYTE_W-1:0];

  always_comb begin
    case (st.addrSel)
      A_SP1:   memAddr = spQ + ADDR_W'(1);
      A_SPM1:  memAddr = spQ - ADDR_W'(1);
      A_SPM2:  memAddr = spQ - ADDR_W'(2);
      default: memAddr = spQ;
    endcase
  end

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pairOut
      assign pairsOut[p] = pairQ[p];
    end
    for (genvar s = 0; s < SHADOWS; s++) begin : g_shOut
      assign shadowOut[s] = shQ[s];
    end
  endgenerate

  assign spOut   = spQ;
  assign iff1Out = iff1Q;
  assign iff2Out = iff2Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAIRS; i++)   pairQ[i] <= '0;
      for (int i = 0; i < SHADOWS; i++) shQ[i]   <= '0;
      spQ   <= '0;
      tmpQ  <= '0;
      iff1Q <= 1'b0;
      iff2Q <= 1'b0;
    end else begin
      if (st.capLo) tmpQ[BYTE_W-1:0]      <= memRdata;
      if (st.capHi) tmpQ[WORD_W-1:BYTE_W] <= memRdata;
      if (st.exDeHl) begin
        pairQ[IDX_DE] <= pairQ[IDX_HL];
        pairQ[IDX_HL] <= pairQ[IDX_DE];
      end
      if (st.exx) begin
        for (int i = 0; i < SHADOWS; i++) begin
          pairQ[i] <= shQ[i];
          shQ[i]   <= pairQ[i];
        end
      end
      if (st.spFromHl) spQ <= pairQ[IDX_HL];
      if (st.intOff) begin
        iff1Q <= 1'b0;
        iff2Q <= 1'b0;
      end
      if (st.intOn) begin
        iff1Q <= 1'b1;
        iff2Q <= 1'b1;
      end
      if (st.pushDone) spQ <= spQ - ADDR_W'(2);
      if (st.popDone) begin
        pairQ[st.pairSel] <= {memRdata, tmpQ[BYTE_W-1:0]};
        spQ <= spQ + ADDR_W'(2);
      end
      if (st.exSpDone) pairQ[IDX_HL] <= tmpQ;
      if (st.hostOk && wrEn) begin
        case (wrSel)
          3'd0: pairQ[0] <= wrData;
          3'd1: pairQ[1] <= wrData;
          3'd2: pairQ[2] <= wrData;
          3'd3: pairQ[3] <= wrData;
          3'd4: spQ      <= wrData;
          3'd5: shQ[0]   <= wrData;
          3'd6: shQ[1]   <= wrData;
          default: shQ[2] <= wrData;
        endcase
      end
    end
  end
endmodule

// File: rtl/regx_stack_unit.sv
module regx_stack_unit
  import regx_stack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [7:0]          opCode,
  output logic                busy,
  output logic                opDone,
  output logic [TS_W-1:0]     tStates,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTE_W-1:0]   memWdata,
  input  logic [BYTE_W-1:0]   memRdata,
  input  logic                memDone,
  input  logic                wrEn,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   regBC,
  output logic [WORD_W-1:0]   regDE,
  output logic [WORD_W-1:0]   regHL,
  output logic [WORD_W-1:0]   regAF,
  output logic [WORD_W-1:0]   shBC,
  output logic [WORD_W-1:0]   shDE,
  output logic [WORD_W-1:0]   shHL,
  output logic [ADDR_W-1:0]   regSP,
  output logic                iff1,
  output logic                iff2
);
  strobe_t                           st;
  logic [PAIRS-1:0][WORD_W-1:0]      pairsOut;
  logic [SHADOWS-1:0][WORD_W-1:0]    shadowOut;

  regx_stack_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .memDone(memDone), .st(st), .memReq(memReq), .memWe(memWe),
    .busy(busy), .opDone(opDone), .tStates(tStates)
  );

  regx_stack_dpath i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .memRdata(memRdata),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .memAddr(memAddr), .memWdata(memWdata),
    .pairsOut(pairsOut), .shadowOut(shadowOut), .spOut(regSP),
    .iff1Out(iff1), .iff2Out(iff2)
  );

  assign regBC = pairsOut[0];
  assign regDE = pairsOut[1];
  assign regHL = pairsOut[2];
  assign regAF = pairsOut[3];
  assign shBC  = shadowOut[0];
  assign shDE  = shadowOut[1];
  assign shHL  = shadowOut[2];
endmodule

// File: rtl/regx_stack_unit_chk.sv
module regx_stack_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [7:0]  opCode,
  input logic        busy,
  input logic        opDone,
  input logic [4:0]  tStates,
  input logic        memReq,
  input logic        memWe,
  input logic [15:0] memAddr,
  input logic [7:0]  memWdata,
  input logic        memDone,
  input logic [15:0] regBC,
  input logic [15:0] regDE,
  input logic [15:0] regHL,
  input logic [15:0] regAF,
  input logic [15:0] shBC,
  input logic [15:0] shDE,
  input logic [15:0] shHL,
  input logic [15:0] regSP,
  input logic        iff1,
  input logic        iff2
);
  logic accept, known;
  assign accept = opValid && !busy;
  assign known  = (opCode[7:6] == 2'b11 && (opCode[3:0] == 4'h5 || opCode[3:0] == 4'h1))
               || opCode == 8'hD9 || opCode == 8'hEB || opCode == 8'hE3
               || opCode == 8'hF9 || opCode == 8'hF3 || opCode == 8'hFB;

  a_r10_di: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opCode == 8'hF3) |=> (!iff1 && !iff2 && opDone && tStates == 5'd4));

  a_r10_ei: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opCode == 8'hFB) |=> (iff1 && iff2 && opDone && tStates == 5'd4));

  a_r6_exx: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opCode == 8'hD9) |=> (regBC == $past(shBC) && shBC == $past(regBC)
      && regDE == $past(shDE) && shDE == $past(regDE)
      && regHL == $past(shHL) && shHL == $past(regHL)
      && regAF == $past(regAF) && tStates == 5'd4));

  a_r7_swap: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opCode == 8'hEB) |=> (regDE == $past(regHL) && regHL == $past(regDE)));

  a_r9_ldsp: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opCode == 8'hF9) |=> (regSP == $past(regHL) && tStates == 5'd6));

  a_r12_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !known) |=> (opDone && !busy && tStates == 5'd0));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && opDone));

  a_r8_sp_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memDone) |=> $stable(regSP));
endmodule

bind regx_stack_unit regx_stack_unit_chk i_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .busy(busy),
  .opDone(opDone), .tStates(tStates), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memDone(memDone),
  .regBC(regBC), .regDE(regDE), .regHL(regHL), .regAF(regAF),
  .shBC(shBC), .shDE(shDE), .shHL(shHL), .regSP(regSP),
  .iff1(iff1), .iff2(iff2)
);

// File: tb/test_regx_stack_unit.sv
module test_regx_stack_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic busy, opDone, memReq, memWe;
  logic [4:0] tStates;
  logic [15:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = 8'h00;
  logic memDone = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] regBC, regDE, regHL, regAF, shBC, shDE, shHL, regSP;
  logic iff1, iff2;

  always #4 clk = ~clk;

  regx_stack_unit i_regx_stack_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .busy(busy),
    .opDone(opDone), .tStates(tStates), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memDone(memDone),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .regBC(regBC), .regDE(regDE), .regHL(regHL), .regAF(regAF),
    .shBC(shBC), .shDE(shDE), .shHL(shHL), .regSP(regSP), .iff1(iff1), .iff2(iff2)
  );

  int nChecks = 0;
  int nFails = 0;
  bit started = 0;
  string curTag = "R1";

  logic [7:0] mem [int];
  logic [7:0] refMem [int];
  int accCnt = 0;
  int waitCnt = 0;

  logic [15:0] ePair [4];
  logic [15:0] eSh [3];
  logic [15:0] eSp;
  logic eI1, eI2;

  function automatic logic [7:0] rdMem(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rdRef(logic [15:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
  endfunction

  // memory responder with varying latency
  always @(posedge clk) begin
    memDone <= 1'b0;
    if (memReq && !memDone) begin
      if (waitCnt == 0) begin
        memDone <= 1'b1;
        if (memWe) mem[int'(memAddr)] = memWdata;
        else memRdata <= rdMem(int'(memAddr));
        accCnt++;
        waitCnt = accCnt % 3;
      end else waitCnt--;
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  function automatic logic [175:0] actState();
    return {regBC, regDE, regHL, regAF, shBC, shDE, shHL, regSP,
            14'd0, iff1, iff2};
  endfunction
  function automatic logic [175:0] expState();
    return {ePair[0], ePair[1], ePair[2], ePair[3], eSh[0], eSh[1], eSh[2], eSp,
            14'd0, eI1, eI2};
  endfunction

  // per-clock comparison against the model while no completion is pending
  always @(negedge clk) begin
    if (started && rstN && !opDone) check(curTag, "state", actState(), expState());
  end

  task automatic fullCompare(string tag);
    check(tag, "BC", regBC, ePair[0]);
    check(tag, "DE", regDE, ePair[1]);
    check(tag, "HL", regHL, ePair[2]);
    check(tag, "AF", regAF, ePair[3]);
    check(tag, "shBC", shBC, eSh[0]);
    check(tag, "shDE", shDE, eSh[1]);
    check(tag, "shHL", shHL, eSh[2]);
    check(tag, "SP", regSP, eSp);
    check(tag, "iff", {iff1, iff2}, {eI1, eI2});
    foreach (refMem[k]) check(tag, $sformatf("mem[%0h]", k), rdMem(k), refMem[k]);
  endtask

  function automatic int costFor(logic [7:0] op);
    if (op[7:6] == 2'b11 && op[3:0] == 4'h5) return 11;
    if (op[7:6] == 2'b11 && op[3:0] == 4'h1) return 10;
    case (op)
      8'hE3: return 19;
      8'hF9: return 6;
      8'hD9, 8'hEB, 8'hF3, 8'hFB: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int accessesFor(logic [7:0] op);
    if (op[7:6] == 2'b11 && (op[3:0] == 4'h5 || op[3:0] == 4'h1)) return 2;
    if (op == 8'hE3) return 4;
    return 0;
  endfunction

  task automatic applyModel(logic [7:0] op);
    int n;
    logic [15:0] t;
    n = op[5:4];
    if (op[7:6] == 2'b11 && op[3:0] == 4'h5) begin
      refMem[int'(16'(eSp - 16'd1))] = ePair[n][15:8];
      refMem[int'(16'(eSp - 16'd2))] = ePair[n][7:0];
      eSp = eSp - 16'd2;
    end else if (op[7:6] == 2'b11 && op[3:0] == 4'h1) begin
      ePair[n] = {rdRef(16'(eSp + 16'd1)), rdRef(eSp)};
      eSp = eSp + 16'd2;
    end else begin
      case (op)
        8'hD9: for (int i = 0; i < 3; i++) begin t = ePair[i]; ePair[i] = eSh[i]; eSh[i] = t; end
        8'hEB: begin t = ePair[1]; ePair[1] = ePair[2]; ePair[2] = t; end
        8'hE3: begin
          t = {rdRef(16'(eSp + 16'd1)), rdRef(eSp)};
          refMem[int'(eSp)] = ePair[2][7:0];
          refMem[int'(16'(eSp + 16'd1))] = ePair[2][15:8];
          ePair[2] = t;
        end
        8'hF9: eSp = ePair[2];
        8'hF3: begin eI1 = 0; eI2 = 0; end
        8'hFB: begin eI1 = 1; eI2 = 1; end
        default: ;
      endcase
    end
  endtask

  task automatic hostWrite(logic [2:0] sel, logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 0;
    if (sel < 4) ePair[sel] = d;
    else if (sel == 4) eSp = d;
    else eSh[sel - 5] = d;
  endtask

  task automatic runOp(logic [7:0] op, string tag, bit pokeWhileBusy = 0);
    int cyc, acc0;
    curTag = tag;
    @(negedge clk);
    acc0 = accCnt;
    opValid = 1; opCode = op;
    @(posedge clk);
    #1;
    opValid = 0;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pokeWhileBusy && cyc == 1) begin wrEn = 1; wrSel = 3'd0; wrData = 16'hDEAD; end
      if (pokeWhileBusy && cyc == 2) wrEn = 0;
      if (opDone) break;
    end
    applyModel(op);
    check(tag, "tStates", tStates, costFor(op));
    check("R13", "accesses", accCnt - acc0, accessesFor(op));
    if (accessesFor(op) == 0) check(tag, "latency", cyc, 1);
    fullCompare(tag);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] saved [6];
    for (int i = 0; i < 4; i++) ePair[i] = 0;
    for (int i = 0; i < 3; i++) eSh[i] = 0;
    eSp = 0; eI1 = 0; eI2 = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    fullCompare("R1");
    check("R1", "memReq/busy/opDone", {memReq, busy, opDone}, 3'b000);
    started = 1;

    // R2 loads
    curTag = "R2";
    hostWrite(3'd0, 16'h1234); hostWrite(3'd1, 16'h5678);
    hostWrite(3'd2, 16'h9ABC); hostWrite(3'd3, 16'hA5C3);
    hostWrite(3'd4, 16'h8000); hostWrite(3'd5, 16'h1111);
    hostWrite(3'd6, 16'h2222); hostWrite(3'd7, 16'h3333);
    @(negedge clk);
    fullCompare("R2");

    // R3 pushes, R5 AF byte order
    runOp(8'hC5, "R3"); runOp(8'hD5, "R3"); runOp(8'hE5, "R3");
    runOp(8'hF5, "R5");
    check("R5", "A at SP+1", rdMem(int'(regSP) + 1), 8'hA5);
    check("R5", "flags at SP", rdMem(int'(regSP)), 8'hC3);
    // R4 pops in shuffled order
    runOp(8'hC1, "R4"); runOp(8'hF1, "R5"); runOp(8'hD1, "R4"); runOp(8'hE1, "R4");

    // R6 double bank swap restores
    saved = '{regBC, regDE, regHL, shBC, shDE, shHL};
    runOp(8'hD9, "R6");
    runOp(8'hD9, "R6");
    check("R6", "restore BC", regBC, saved[0]);
    check("R6", "restore shHL", shHL, saved[5]);

    runOp(8'hEB, "R7");

    // R8 stack top exchange
    hostWrite(3'd4, 16'h4000);
    mem[32'h4000] = 8'h55; mem[32'h4001] = 8'hAA;
    refMem[32'h4000] = 8'h55; refMem[32'h4001] = 8'hAA;
    runOp(8'hE3, "R8");
    check("R8", "HL old word", regHL, 16'hAA55);

    runOp(8'hF9, "R9");
    runOp(8'hFB, "R10"); runOp(8'hF3, "R10"); runOp(8'hFB, "R10");

    // R11 wrap at the bottom and top of the address space
    hostWrite(3'd4, 16'h0000);
    runOp(8'hC5, "R11");
    check("R11", "SP after push", regSP, 16'hFFFE);
    runOp(8'hE1, "R11");
    check("R11", "SP after pop", regSP, 16'h0000);
    hostWrite(3'd4, 16'hFFFF);
    mem[0] = 8'h77; refMem[0] = 8'h77;
    runOp(8'hD1, "R11");
    check("R11", "SP wrapped", regSP, 16'h0001);

    // R12 unrecognised opcodes
    runOp(8'h00, "R12"); runOp(8'hC9, "R12"); runOp(8'hE9, "R12");

    // R2 load during a running instruction is dropped
    runOp(8'hF5, "R2", 1);
    check("R2", "BC untouched", regBC, ePair[0]);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule